// File: doc/BRIEF.md
# Adaptive Per-Bit Transition-Reducing Bus Codec

This block cuts switching activity on a wide, heavily loaded bus when nothing is known in advance about the data it carries. Every bit line has its own slice. Each slice watches the pairs of consecutive values on its input bit, one pair per cycle, over a fixed window. It keeps two weighted sums of how often the bit held steady at 0 and held steady at 1. At the end of each window the slice looks only at the top bits of those sums. From them it picks one of four single-gate functions: pass, invert, XOR with the previous bit, or XNOR with the previous bit. That function is used for the whole of the next window. The function output feeds a decorrelator, so a 1 toggles the bus line and a 0 leaves it still.

The receiving side undoes the decorrelator and applies the same self-inverse function. It rebuilds each function choice from statistics taken on its own decoded output. Encoder and decoder therefore stay in step with no extra wires. The top module holds both sides joined by the bus. It exposes the driven bus value and the recovered data, which trails the input by one cycle.

Top module: `adaptive_bus_codec`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, `bus_o` and `data_o` are all zeros. All history, statistics and window state restart, and every bit returns to the pass-through function.
- R2: Each bus line is registered. In every cycle a line toggles exactly when that bit's encoded value is 1, and holds otherwise.
- R3: During the first window after reset every bit uses pass-through. A line therefore toggles exactly in the cycles whose input bit is 1.
- R4: For each bit, the pair seen in a cycle is (previous input bit, current input bit). The previous bit is 0 for the first pair after reset. A window is 2^WIN_LOG2 consecutive pairs. At the end of a window the counts of 0-0 pairs (N00) and 1-1 pairs (N11) are cleared before the next window starts.
- R5: At each window end a bit sets s0 = (3·N00 + N11 ≥ 2^WIN_LOG2) and s1 = (N00 + 3·N11 ≥ 2^WIN_LOG2), counting the window's last pair. The selections are {s0,s1} = 10 pass, 01 invert, 11 XOR with previous bit, 00 XNOR with previous bit.
- R6: The encoded bit is x for pass, ~x for invert, x^p for XOR and ~(x^p) for XNOR. Here x is the current input bit and p the previous one.
- R7: A function chosen at a window end is used from the next cycle for exactly one full window. It changes at no other time.
- R8: `data_o` equals the value `data_i` had in the previous cycle, from the first cycle after reset onward.
- R9: Each bit's function depends only on that bit's own input stream. Bits with different streams in the same window can hold different functions.
- R10: One window counter serves all bits of a side, so all bits switch function in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Word presented to the encoder each cycle |
| bus_o | output | WIDTH | Registered, decorrelated bus lines |
| data_o | output | WIDTH | Word recovered by the decoder, one cycle late |

## Verification
The bench builds the codec with a 4-bit bus and an 8-pair window. This makes the accumulators 5 bits wide and lets several hundred windows run in a few thousand cycles. Each bit gets a different pattern per window: steady zeros, steady ones, alternating, pseudo-random, and sparse toggles. As a result, every bit passes through all four functions, including the exact threshold cases where 3·N00+N11 equals the window size. A second reset in mid-stream shows that the function state and history return to their start values.

// File: rtl/abc_pkg.sv
package abc_pkg;

  // encoding is {s0, s1}
  typedef enum logic [1:0] {
    FN_XNOR = 2'b00,
    FN_INV  = 2'b01,
    FN_PASS = 2'b10,
    FN_XOR  = 2'b11
  } fn_e;

  // self-inverse: applying it to the encoded bit with the same history restores x
  function automatic logic apply_fn(fn_e fn, logic x, logic p);
    unique case (fn)
      FN_PASS: apply_fn = x;
      FN_INV:  apply_fn = ~x;
      FN_XOR:  apply_fn = x ^ p;
      default: apply_fn = ~(x ^ p);
    endcase
  endfunction

endpackage

// File: rtl/abc_window_ctr.sv
module abc_window_ctr #(
  parameter int WIN_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic last_o
);

  logic [WIN_LOG2-1:0] cnt_q;

  assign last_o = en_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (cnt_q == '0));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/abc_bit_stats.sv
module abc_bit_stats import abc_pkg::*; #(
  parameter int WIN_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic last_i,
  input  logic prev_i,
  input  logic cur_i,
  output fn_e  fn_o
);

  localparam int ACC_W   = WIN_LOG2 + 2;
  localparam int WIN     = 1 << WIN_LOG2;
  localparam int ACC_MAX = 3 * (WIN - 1);

  logic             hold0, hold1;
  logic [ACC_W-1:0] inc_a, inc_b;
  logic [ACC_W-1:0] acc_a_q, acc_b_q, acc_a_d, acc_b_d;
  logic             s0, s1;
  fn_e              fn_q;

  assign hold0 = !prev_i && !cur_i;
  assign hold1 =  prev_i &&  cur_i;

  // acc_a tracks 3*N00 + N11, acc_b tracks N00 + 3*N11
  always_comb begin
    inc_a = '0;
    inc_b = '0;
    if (hold0) begin
      inc_a = ACC_W'(3);
      inc_b = ACC_W'(1);
    end else if (hold1) begin
      inc_a = ACC_W'(1);
      inc_b = ACC_W'(3);
    end
  end

  assign acc_a_d = acc_a_q + inc_a;
  assign acc_b_d = acc_b_q + inc_b;

  // reaching the window size sets a bit above WIN_LOG2
  assign s0 = |acc_a_d[ACC_W-1:WIN_LOG2];
  assign s1 = |acc_b_d[ACC_W-1:WIN_LOG2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_a_q <= '0;
      acc_b_q <= '0;
      fn_q    <= FN_PASS;
    end else if (en_i) begin
      if (last_i) begin
        acc_a_q <= '0;
        acc_b_q <= '0;
        fn_q    <= fn_e'({s0, s1});
      end else begin
        acc_a_q <= acc_a_d;
        acc_b_q <= acc_b_d;
      end
    end
  end

  assign fn_o = fn_q;

  p_acc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(acc_a_q) <= ACC_MAX) && (int'(acc_b_q) <= ACC_MAX));

  p_acc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && last_i) |=> (acc_a_q == '0 && acc_b_q == '0));

  p_fn_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && last_i) |=> $stable(fn_q));

endmodule

// File: rtl/abc_encoder.sv
module abc_encoder import abc_pkg::*; #(
  parameter int WIDTH    = 8,
  parameter int WIN_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] bus_o
);

  logic             win_last;
  logic [WIDTH-1:0] prev_q, enc, bus_q;
  fn_e              fn [WIDTH];

  abc_window_ctr #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (1'b1),
    .last_o (win_last)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    abc_bit_stats #(.WIN_LOG2(WIN_LOG2)) u_stats (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (1'b1),
      .last_i (win_last),
      .prev_i (prev_q[b]),
      .cur_i  (data_i[b]),
      .fn_o   (fn[b])
    );

    assign enc[b] = apply_fn(fn[b], data_i[b], prev_q[b]);

    p_pass_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fn[b] == FN_PASS) |=> ((bus_q[b] != $past(bus_q[b])) == $past(data_i[b])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      bus_q  <= '0;
    end else begin
      prev_q <= data_i;
      bus_q  <= bus_q ^ enc;  // decorrelator
    end
  end

  assign bus_o = bus_q;

endmodule

// File: rtl/abc_decoder.sv
module abc_decoder import abc_pkg::*; #(
  parameter int WIDTH    = 8,
  parameter int WIN_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] data_o,
  output logic             started_o
);

  logic             started_q, win_last;
  logic [WIDTH-1:0] prev_bus_q, prev_q, enc_rx;
  fn_e              fn [WIDTH];

  // stats lag the encoder by one cycle, so they start one cycle later
  abc_window_ctr #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (started_q),
    .last_o (win_last)
  );

  assign enc_rx = bus_i ^ prev_bus_q;  // correlator

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    abc_bit_stats #(.WIN_LOG2(WIN_LOG2)) u_stats (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (started_q),
      .last_i (win_last),
      .prev_i (prev_q[b]),
      .cur_i  (data_o[b]),
      .fn_o   (fn[b])
    );

    assign data_o[b] = apply_fn(fn[b], enc_rx[b], prev_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q  <= 1'b0;
      prev_bus_q <= '0;
      prev_q     <= '0;
    end else begin
      started_q  <= 1'b1;
      prev_bus_q <= bus_i;
      prev_q     <= data_o;
    end
  end

  assign started_o = started_q;

  p_started_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q);

endmodule

// File: rtl/adaptive_bus_codec.sv
module adaptive_bus_codec #(
  parameter int WIDTH    = 8,
  parameter int WIN_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] bus_o,
  output logic [WIDTH-1:0] data_o
);

  logic [WIDTH-1:0] bus;
  logic             dec_started;

  abc_encoder #(.WIDTH(WIDTH), .WIN_LOG2(WIN_LOG2)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .bus_o  (bus)
  );

  abc_decoder #(.WIDTH(WIDTH), .WIN_LOG2(WIN_LOG2)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_i     (bus),
    .data_o    (data_o),
    .started_o (dec_started)
  );

  assign bus_o = bus;

  p_round_trip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_started |-> (data_o == $past(data_i)));

  p_first_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_started |-> (data_o == '0));

endmodule

// File: tb/adaptive_bus_codec_bench.sv
module adaptive_bus_codec_bench;
  localparam int  W = 4;
  localparam int  WL = 3;
  localparam int  S = 1 << WL;
  localparam time CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] bus_o, data_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adaptive_bus_codec #(.WIDTH(W), .WIN_LOG2(WL)) u_adaptive_bus_codec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .bus_o  (bus_o),
    .data_o (data_o)
  );

  // reference model, {s0,s1}: 10 pass, 01 invert, 11 xor, 00 xnor
  logic [1:0]   m_fn [W];
  int           m_n00 [W];
  int           m_n11 [W];
  int           m_cnt;
  logic [W-1:0] m_px, m_bus;
  logic [15:0]  lfsr = 16'hACE1;

  task automatic check(input logic ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic enc_bit(input logic [1:0] f, input logic x, input logic p);
    case (f)
      2'b10:   return x;
      2'b01:   return ~x;
      2'b11:   return x ^ p;
      default: return ~(x ^ p);
    endcase
  endfunction

  task automatic model_reset();
    for (int b = 0; b < W; b++) begin
      m_fn[b]  = 2'b10;
      m_n00[b] = 0;
      m_n11[b] = 0;
    end
    m_cnt = 0;
    m_px  = '0;
    m_bus = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    data_i = '0;
    repeat (2) @(negedge clk_i);
    model_reset();
    check(bus_o == '0, "R1 bus in reset", bus_o, '0);
    check(data_o == '0, "R1 data in reset", data_o, '0);
    rst_ni = 1'b1;
    #1;
    check(data_o == '0, "R1 data after release", data_o, '0);
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic [W-1:0] x, input logic first_win);
    logic [W-1:0] nb;
    for (int b = 0; b < W; b++) nb[b] = m_bus[b] ^ enc_bit(m_fn[b], x[b], m_px[b]);
    data_i = x;
    @(negedge clk_i);
    check(bus_o == nb, "R2 R4 R5 R6 R7 R9 R10 bus", bus_o, nb);
    check(data_o == x, "R8 recovered data", data_o, x);
    if (first_win) check((bus_o ^ m_bus) == x, "R3 pass-through toggles", bus_o ^ m_bus, x);
    for (int b = 0; b < W; b++) begin
      if (!m_px[b] && !x[b]) m_n00[b]++;
      if (m_px[b] && x[b])   m_n11[b]++;
    end
    m_bus = nb;
    m_px  = x;
    m_cnt++;
    if (m_cnt == S) begin
      for (int b = 0; b < W; b++) begin
        m_fn[b]  = {(3*m_n00[b] + m_n11[b]) >= S, (m_n00[b] + 3*m_n11[b]) >= S};
        m_n00[b] = 0;
        m_n11[b] = 0;
      end
      m_cnt = 0;
    end
  endtask

  function automatic logic pat_bit(input int kind, input int pos, input logic rnd);
    case (kind)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return pos[0];
      3:       return rnd;
      4:       return !(pos == 0 || pos == 3);
      default: return (pos == 2 || pos == 5);
    endcase
  endfunction

  task automatic run_windows(input int nwin);
    for (int w = 0; w < nwin; w++) begin
      for (int i = 0; i < S; i++) begin
        logic [W-1:0] x;
        for (int b = 0; b < W; b++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          x[b] = pat_bit((w * 3 + b * 7 + w / 5) % 6, i, lfsr[0]);
        end
        step(x, (w == 0));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    run_windows(300);
    do_reset();
    run_windows(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule